// File: doc/BRIEF.md
# Direct-Mapped Word Cache with Selectable Write Policy

This block sits between a processor and a slower main memory. It keeps one word per line in a RAM that the low address bits index. Each line also stores the upper address bits, a valid bit and a dirty flag. A request is accepted when `cpu_ready` is high. The cache then looks up the line. A hit completes in the next cycle. A miss goes out on a simple request/acknowledge memory port.

The parameter `WRITE_BACK` selects the write policy when the block is built. With `WRITE_BACK=0`, every write goes straight to memory, and a write miss does not claim a line. With `WRITE_BACK=1`, a write stays in the cache and marks the line dirty. A dirty line is copied back to memory before another address takes its place.

An initialisation pass runs after reset and again whenever `init_req` is pulsed. It walks the lines one per cycle and marks each of them invalid. `busy` is high for the whole pass.

The controller has six named states:
- `S_INIT` clears one line per cycle. After the last line it goes to `S_IDLE`.
- `S_IDLE` waits. It goes to `S_INIT` on `init_req`, which has priority, and otherwise to `S_LOOK` on `cpu_req`.
- `S_LOOK` compares the stored tag with the request tag. It then returns to `S_IDLE` (read hit, or write handled in the cache), or goes to `S_EVICT` (dirty victim in write-back), `S_FILL` (read miss) or `S_WMEM` (write in write-through).
- `S_EVICT` writes the victim word to memory. It then goes to `S_FILL` for a read, or back to `S_IDLE` for a write that installs its own word.
- `S_FILL` reads the word from memory, installs it and returns to `S_IDLE`.
- `S_WMEM` writes the request word to memory and returns to `S_IDLE`.

Top module: `dmc_cache`

## Requirements
- R1: The index is `cpu_addr[8:0]` and the tag is `cpu_addr[14:9]`. A dirty victim is written to the memory address formed as {stored tag, index}, with the stored word as data.
- R2: A read hit raises `cpu_done` with `cpu_hit`=1 in the cycle after acceptance. `cpu_rdata` holds the stored word, and no memory transfer takes place.
- R3: A read miss fetches the word at the request address. The word is installed as a clean, valid line and returned with `cpu_hit`=0. A repeat read of that address then hits.
- R4: After reset, and after an `init_req` pulse accepted in idle, `busy` stays high for exactly 512 cycles. While `busy` is high, `cpu_ready` is low and requests are ignored. Afterwards every line is invalid.
- R5: In write-through mode, every write causes exactly one memory write of the request word to the request address. A write hit also updates the cached word and reports `cpu_hit`=1.
- R6: In write-through mode, a write miss installs no line, so a following read of that address misses.
- R7: In write-back mode, a write hit updates only the cache, sets the dirty flag and completes with no memory transfer.
- R8: In write-back mode, replacing a dirty line first writes its old word to memory. Replacing a clean line writes nothing.
- R9: In write-back mode, a write miss claims the line without fetching it and marks it dirty. Any dirty victim is written back first.
- R10: Two addresses with the same index but different tags never hit one after the other. Each one evicts the other.
- R11: `mem_req` stays high, with `mem_we`, `mem_addr` and `mem_wdata` unchanged, until `mem_ack`. Each acknowledge completes exactly one transfer.
- R12: `cpu_done` is a one-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts an initialisation pass |
| init_req | input | 1 | Pulse in idle to invalidate all lines |
| cpu_req | input | 1 | Request, accepted when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 15 | Request address |
| cpu_wdata | input | 12 | Write word |
| cpu_ready | output | 1 | Idle and able to accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Hit flag, valid with `cpu_done` |
| cpu_rdata | output | 12 | Read word, valid with `cpu_done` on reads |
| busy | output | 1 | Initialisation pass in progress |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 12 | Memory write word |
| mem_ack | input | 1 | One-cycle acknowledge from memory |
| mem_rdata | input | 12 | Memory read word, valid with `mem_ack` |

## Verification
The handshake assertions assume that memory raises `mem_ack` only while `mem_req` is high, and only as a single-cycle pulse. The bench memory model acknowledges one cycle after each new request and drops `mem_ack` right away. The policy assertions assume that requests arrive only while `cpu_ready` is high, and that `init_req` is never raised in the same cycle as a request. The bench drives requests at the falling edge, only while `cpu_ready` is high, and pulses `init_req` only between operations. Bench addresses keep the tag below 4, so the memory model holds every address the bench touches.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [2:0] {
        S_INIT,
        S_IDLE,
        S_LOOK,
        S_EVICT,
        S_FILL,
        S_WMEM
    } dmc_state_e;
endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int IDX_W  = 9,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic              valid_q [LINES];
    logic              dirty_q [LINES];
    logic [TAG_W-1:0]  tag_q   [LINES];
    logic [DATA_W-1:0] data_q  [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
            dirty_q[wr_idx] <= wr_dirty;
            tag_q[wr_idx]   <= wr_tag;
            data_q[wr_idx]  <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int IDX_W      = 9,
    parameter int DATA_W     = 12,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    init_req,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_ready,
    output logic                    cpu_done,
    output logic                    cpu_hit,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    busy,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    mem_ack,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic [IDX_W-1:0]        ln_idx,
    input  logic                    ln_valid,
    input  logic                    ln_dirty,
    input  logic [ADDR_W-IDX_W-1:0] ln_tag,
    input  logic [DATA_W-1:0]       ln_data,
    output logic                    lw_en,
    output logic [IDX_W-1:0]        lw_idx,
    output logic                    lw_valid,
    output logic                    lw_dirty,
    output logic [ADDR_W-IDX_W-1:0] lw_tag,
    output logic [DATA_W-1:0]       lw_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    dmc_state_e        st, nxt;
    logic [IDX_W-1:0]  init_cnt;
    logic              q_we;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata;
    logic              hit_q;
    logic [IDX_W-1:0]  q_idx;
    logic [TAG_W-1:0]  q_tag;
    logic              hit;

    assign q_idx = q_addr[IDX_W-1:0];
    assign q_tag = q_addr[ADDR_W-1:IDX_W];
    assign ln_idx = q_idx;
    assign hit = ln_valid && (ln_tag == q_tag);
    assign cpu_ready = (st == S_IDLE);
    assign busy = (st == S_INIT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_INIT;
        else        st <= nxt;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_cnt <= '0;
            q_we     <= 1'b0;
            q_addr   <= '0;
            q_wdata  <= '0;
            hit_q    <= 1'b0;
        end else begin
            if (st == S_INIT) init_cnt <= init_cnt + 1'b1;
            else if (st == S_IDLE && init_req) init_cnt <= '0;
            if (st == S_IDLE && !init_req && cpu_req) begin
                q_we    <= cpu_we;
                q_addr  <= cpu_addr;
                q_wdata <= cpu_wdata;
            end
            if (st == S_LOOK) hit_q <= hit;
        end
    end

    // Next state and outputs
    always_comb begin
        nxt       = st;
        cpu_done  = 1'b0;
        cpu_hit   = 1'b0;
        cpu_rdata = ln_data;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q_addr;
        mem_wdata = q_wdata;
        lw_en     = 1'b0;
        lw_idx    = q_idx;
        lw_valid  = 1'b1;
        lw_dirty  = 1'b0;
        lw_tag    = q_tag;
        lw_data   = q_wdata;
        unique case (st)
            S_INIT: begin
                lw_en    = 1'b1;
                lw_idx   = init_cnt;
                lw_valid = 1'b0;
                if (&init_cnt) nxt = S_IDLE;
            end
            S_IDLE: begin
                if (init_req)     nxt = S_INIT;
                else if (cpu_req) nxt = S_LOOK;
            end
            S_LOOK: begin
                if (hit) begin
                    if (!q_we) begin
                        cpu_done = 1'b1;
                        cpu_hit  = 1'b1;
                        nxt      = S_IDLE;
                    end else begin
                        lw_en    = 1'b1;
                        lw_dirty = WRITE_BACK;
                        if (WRITE_BACK) begin
                            cpu_done = 1'b1;
                            cpu_hit  = 1'b1;
                            nxt      = S_IDLE;
                        end else begin
                            nxt = S_WMEM;
                        end
                    end
                end else if (WRITE_BACK && ln_valid && ln_dirty) begin
                    nxt = S_EVICT;
                end else if (q_we) begin
                    if (WRITE_BACK) begin
                        lw_en    = 1'b1;
                        lw_dirty = 1'b1;
                        cpu_done = 1'b1;
                        nxt      = S_IDLE;
                    end else begin
                        nxt = S_WMEM;
                    end
                end else begin
                    nxt = S_FILL;
                end
            end
            S_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {ln_tag, q_idx};
                mem_wdata = ln_data;
                if (mem_ack) begin
                    if (q_we) begin
                        lw_en    = 1'b1;
                        lw_dirty = 1'b1;
                        cpu_done = 1'b1;
                        nxt      = S_IDLE;
                    end else begin
                        nxt = S_FILL;
                    end
                end
            end
            S_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    lw_en     = 1'b1;
                    lw_data   = mem_rdata;
                    cpu_rdata = mem_rdata;
                    cpu_done  = 1'b1;
                    nxt       = S_IDLE;
                end
            end
            S_WMEM: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    cpu_done = 1'b1;
                    cpu_hit  = hit_q;
                    nxt      = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // Memory handshake stays stable until acknowledged (R11)
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // Completion is a single-cycle pulse (R12)
    a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // No traffic or completion during the initialisation pass (R4)
    a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!mem_req && !cpu_done && !cpu_ready));

    // A read hit completes the cycle after acceptance (R2)
    a_r2_fast_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && cpu_hit && !q_we) |-> ($past(st) == S_IDLE));

    generate
        if (WRITE_BACK) begin : g_wb
            // Victim write shares the index and carries a different tag (R1, R8)
            a_r8_victim: assert property (@(posedge clk) disable iff (!rst_n)
                (mem_req && mem_we) |-> (mem_addr[IDX_W-1:0] == q_idx && mem_addr[ADDR_W-1:IDX_W] != q_tag));
        end else begin : g_wt
            // Every memory write carries the request itself (R5)
            a_r5_through: assert property (@(posedge clk) disable iff (!rst_n)
                (mem_req && mem_we) |-> (mem_addr == q_addr && mem_wdata == q_wdata));
        end
    endgenerate
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int ADDR_W     = 15,
    parameter int IDX_W      = 9,
    parameter int DATA_W     = 12,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  ln_idx, lw_idx;
    logic              ln_valid, ln_dirty, lw_en, lw_valid, lw_dirty;
    logic [TAG_W-1:0]  ln_tag, lw_tag;
    logic [DATA_W-1:0] ln_data, lw_data;

    dmc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk),
        .rd_idx(ln_idx), .rd_valid(ln_valid), .rd_dirty(ln_dirty),
        .rd_tag(ln_tag), .rd_data(ln_data),
        .wr_en(lw_en), .wr_idx(lw_idx), .wr_valid(lw_valid),
        .wr_dirty(lw_dirty), .wr_tag(lw_tag), .wr_data(lw_data)
    );

    dmc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .WRITE_BACK(WRITE_BACK)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .init_req(init_req),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
        .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ln_idx(ln_idx), .ln_valid(ln_valid), .ln_dirty(ln_dirty), .ln_tag(ln_tag), .ln_data(ln_data),
        .lw_en(lw_en), .lw_idx(lw_idx), .lw_valid(lw_valid), .lw_dirty(lw_dirty),
        .lw_tag(lw_tag), .lw_data(lw_data)
    );
endmodule

// File: tb/sim_dmc_cache.sv
`timescale 1ns/1ps
module sim_mem (
    input  logic        clk,
    input  logic        req,
    input  logic        we,
    input  logic [14:0] addr,
    input  logic [11:0] wdata,
    output logic        ack,
    output logic [11:0] rdata,
    output int          wcnt,
    output logic [14:0] last_wa,
    output logic [11:0] last_wd
);
    logic [11:0] mem [2048];
    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 12'(i * 7 + 3);
        ack = 1'b0; rdata = '0; wcnt = 0; last_wa = '0; last_wd = '0;
    end
    always @(posedge clk) begin
        if (req && !ack) begin
            ack   <= 1'b1;
            rdata <= mem[addr[10:0]];
            if (we) begin
                mem[addr[10:0]] <= wdata;
                wcnt    <= wcnt + 1;
                last_wa <= addr;
                last_wd <= wdata;
            end
        end else begin
            ack <= 1'b0;
        end
    end
endmodule

module sim_dmc_cache;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0]  c_req = '0, c_we = '0, c_init = '0;
    logic [14:0] c_addr [2];
    logic [11:0] c_wd   [2];
    logic [1:0]  c_ready, c_done, c_hit, c_busy;
    logic [11:0] c_rd [2];
    logic        m_req [2];
    logic        m_we  [2];
    logic        m_ack [2];
    logic [14:0] m_addr [2];
    logic [11:0] m_wd [2];
    logic [11:0] m_rd [2];
    int          m_wcnt [2];
    logic [14:0] m_lwa [2];
    logic [11:0] m_lwd [2];

    int checks = 0, failures = 0;
    bit finished = 0;

    for (genvar g = 0; g < 2; g++) begin : g_inst
        sim_mem u_mem (.clk(clk), .req(m_req[g]), .we(m_we[g]), .addr(m_addr[g]), .wdata(m_wd[g]),
                       .ack(m_ack[g]), .rdata(m_rd[g]), .wcnt(m_wcnt[g]),
                       .last_wa(m_lwa[g]), .last_wd(m_lwd[g]));
    end

    dmc_cache #(.WRITE_BACK(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .init_req(c_init[0]), .cpu_req(c_req[0]), .cpu_we(c_we[0]),
        .cpu_addr(c_addr[0]), .cpu_wdata(c_wd[0]), .cpu_ready(c_ready[0]), .cpu_done(c_done[0]),
        .cpu_hit(c_hit[0]), .cpu_rdata(c_rd[0]), .busy(c_busy[0]),
        .mem_req(m_req[0]), .mem_we(m_we[0]), .mem_addr(m_addr[0]), .mem_wdata(m_wd[0]),
        .mem_ack(m_ack[0]), .mem_rdata(m_rd[0]));

    dmc_cache #(.WRITE_BACK(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .init_req(c_init[1]), .cpu_req(c_req[1]), .cpu_we(c_we[1]),
        .cpu_addr(c_addr[1]), .cpu_wdata(c_wd[1]), .cpu_ready(c_ready[1]), .cpu_done(c_done[1]),
        .cpu_hit(c_hit[1]), .cpu_rdata(c_rd[1]), .busy(c_busy[1]),
        .mem_req(m_req[1]), .mem_we(m_we[1]), .mem_addr(m_addr[1]), .mem_wdata(m_wd[1]),
        .mem_ack(m_ack[1]), .mem_rdata(m_rd[1]));

    function automatic logic [11:0] initial_word(input logic [14:0] a);
        return 12'(a * 7 + 3);
    endfunction

    // vector: {we, addr[15], wdata[12], exp_rdata[12], exp_hit, exp_memwrites[2]}
    function automatic logic [42:0] mk(input logic we, input logic [14:0] a, input logic [11:0] wd,
                                       input logic [11:0] erd, input logic eh, input logic [1:0] ew);
        return {we, a, wd, erd, eh, ew};
    endfunction

    localparam int NV = 11;
    localparam logic [42:0] VEC [NV] = '{
        mk(1'b0, 15'h005, 12'h000, initial_word(15'h005), 1'b0, 2'd0), // R3 miss fill
        mk(1'b0, 15'h005, 12'h000, initial_word(15'h005), 1'b1, 2'd0), // R2 hit
        mk(1'b1, 15'h005, 12'hABC, 12'h000,               1'b1, 2'd0), // R7 write hit stays local
        mk(1'b0, 15'h005, 12'h000, 12'hABC,               1'b1, 2'd0), // R7 cache updated
        mk(1'b0, 15'h205, 12'h000, initial_word(15'h205), 1'b0, 2'd1), // R8 dirty victim written back
        mk(1'b0, 15'h005, 12'h000, 12'hABC,               1'b0, 2'd0), // R10 evicted, R8 memory has data
        mk(1'b1, 15'h40A, 12'h123, 12'h000,               1'b0, 2'd0), // R9 write miss allocates
        mk(1'b0, 15'h40A, 12'h000, 12'h123,               1'b1, 2'd0), // R9 allocated line hits
        mk(1'b0, 15'h1FF, 12'h000, initial_word(15'h1FF), 1'b0, 2'd0), // R3 top index
        mk(1'b0, 15'h3FF, 12'h000, initial_word(15'h3FF), 1'b0, 2'd0), // R10, R8 clean victim no write
        mk(1'b0, 15'h1FF, 12'h000, initial_word(15'h1FF), 1'b0, 2'd0)  // R10 conflict again
    };

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    task automatic op(input int s, input logic we, input logic [14:0] a, input logic [11:0] wd,
                      output logic [11:0] rd, output logic h, output int dw);
        int w0, n;
        while (!c_ready[s]) @(negedge clk);
        w0 = m_wcnt[s];
        c_we[s] = we; c_addr[s] = a; c_wd[s] = wd; c_req[s] = 1'b1;
        @(negedge clk);
        c_req[s] = 1'b0;
        n = 0;
        while (!c_done[s] && n < 5000) begin @(negedge clk); n++; end
        rd = c_rd[s]; h = c_hit[s]; dw = m_wcnt[s] - w0;
        @(negedge clk);
        chk("R12 done pulse width", int'(c_done[s]), 0);
    endtask

    task automatic count_busy(input int s, output int n);
        n = 0;
        while (c_busy[s] && n < 5000) begin n++; @(negedge clk); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [11:0] rd;
        logic h;
        int dw, nb;
        c_addr[0] = '0; c_addr[1] = '0; c_wd[0] = '0; c_wd[1] = '0;
        repeat (3) @(negedge clk);
        // Reset state (R4)
        chk("R4 busy in reset", int'(c_busy[0]), 1);
        chk("R12 no done in reset", int'(c_done[0]), 0);
        chk("R11 no mem req in reset", int'(m_req[0]), 0);
        rst_n = 1'b1;
        count_busy(0, nb);
        chk("R4 init pass length", nb, 512);
        chk("R4 ready after init", int'(c_ready[0]), 1);

        // Vector table on the write-back instance
        for (int i = 0; i < NV; i++) begin
            logic [42:0] v;
            v = VEC[i];
            op(0, v[42], v[41:27], v[26:15], rd, h, dw);
            chk($sformatf("R2/R3/R7-R10 vec %0d hit", i), int'(h), int'(v[2]));
            chk($sformatf("R8/R7 vec %0d mem writes", i), dw, int'(v[1:0]));
            if (!v[42]) chk($sformatf("R2/R3 vec %0d rdata", i), int'(rd), int'(v[14:3]));
        end

        // R1: victim address rebuilt from stored tag and index
        op(0, 1'b1, 15'h0C3, 12'h777, rd, h, dw);
        chk("R9 write miss no traffic", dw, 0);
        op(0, 1'b0, 15'h2C3, 12'h000, rd, h, dw);
        chk("R8 eviction count", dw, 1);
        chk("R1 victim address", int'(m_lwa[0]), 'h0C3);
        chk("R1 victim data", int'(m_lwd[0]), 'h777);
        chk("R3 fill data after eviction", int'(rd), int'(initial_word(15'h2C3)));

        // R4: init via init_req; requests during busy are ignored
        @(negedge clk);
        c_init[0] = 1'b1;
        @(negedge clk);
        c_init[0] = 1'b0;
        c_req[0] = 1'b1; c_we[0] = 1'b0; c_addr[0] = 15'h40A;
        nb = 0;
        begin
            int seen_done;
            seen_done = 0;
            while (c_busy[0] && nb < 5000) begin
                if (nb == 3) c_req[0] = 1'b0;
                if (c_done[0] || m_req[0]) seen_done = 1;
                nb++;
                @(negedge clk);
            end
            c_req[0] = 1'b0;
            chk("R4 request ignored while busy", seen_done, 0);
        end
        chk("R4 init_req pass length", nb, 512);
        chk("R4 no done after init", int'(c_done[0]), 0);
        op(0, 1'b0, 15'h40A, 12'h000, rd, h, dw);
        chk("R4 line invalid after init", int'(h), 0);
        chk("R4 dirty line dropped, no write", dw, 0);
        chk("R4 memory word unchanged", int'(rd), int'(initial_word(15'h40A)));

        // Write-through instance
        count_busy(1, nb);
        op(1, 1'b1, 15'h006, 12'h5A5, rd, h, dw);
        chk("R5 write miss hit flag", int'(h), 0);
        chk("R5 write miss one mem write", dw, 1);
        chk("R5 write address", int'(m_lwa[1]), 'h006);
        chk("R5 write data", int'(m_lwd[1]), 'h5A5);
        op(1, 1'b0, 15'h006, 12'h000, rd, h, dw);
        chk("R6 no allocate on write miss", int'(h), 0);
        chk("R6 read returns memory word", int'(rd), 'h5A5);
        op(1, 1'b1, 15'h006, 12'h3C3, rd, h, dw);
        chk("R5 write hit flag", int'(h), 1);
        chk("R5 write hit one mem write", dw, 1);
        op(1, 1'b0, 15'h006, 12'h000, rd, h, dw);
        chk("R5 cached word updated hit", int'(h), 1);
        chk("R5 cached word updated data", int'(rd), 'h3C3);
        chk("R2 hit no mem write", dw, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule